// File: doc/BRIEF.md
# Ping-Pong Traceback Survivor Unit

This block is the survivor stage of a 64-state, rate-1/2 Viterbi decoder. Each trellis stage, the add-compare-select array hands it one decision bit per state and the 64 new path metrics. The decision bits go into a circular memory of 62 stage slots, split into two halves of 31 stages. When a half fills, the unit keeps the metrics of that last stage and scans them one state per clock. The scan uses a wrap-around comparison to find the best state, then walks back through the 31 stored stages of that half. Meanwhile new stages keep filling the other half.

Each backward step emits the top bit of the current state pointer. The pointer then moves to its predecessor. The bits come out newest first, so a small last-in first-out stack turns them around. The 31 decoded bits of the half then leave in time order on consecutive cycles. The parent decoder must space stages so that one half's traceback finishes before the next half fills. Five or more cycles per stage is enough.

Top module: `tsu_traceback_unit`

## Requirements
- R1: After reset, `bit_valid_o` is low and the write slot is 0. The first half therefore closes on the 31st accepted stage.
- R2: Stages are written to slots 0,1,…,61 and then back to 0. The oldest slot is overwritten first, and decoding stays correct across many wraps.
- R3: Accepting slot 30 or slot 61 starts a traceback over that half: slots 30 down to 0, or 61 down to 31. A half must not close while the previous traceback is still running.
- R4: Traceback starts at the state whose metric is smallest among the metrics given with the half's last stage. On a tie, the lower state index wins.
- R5: A traceback step from state s reads decision d of state s at the current slot. It emits bit 5 of s and moves to state ((s mod 32)·2)+d in the previous slot.
- R6: Each traceback yields exactly 31 bits on 31 consecutive `bit_valid_o` cycles. The bits come out in time order, oldest stage first.
- R7: The first output bit is valid in the cycle after the 97th rising edge that follows the edge accepting the half's last stage.
- R8: If the metrics and decisions come from error-free 171/133 encoded symbols, the output stream equals the encoder input stream.
- R9: Metrics compare modulo 2^MET_W: a is smaller than b when bit MET_W-1 of (a−b) is set.
- R10: Stages written into one half while the other half is being traced do not disturb the traceback in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stage_valid_i | input | 1 | One trellis stage is offered this cycle |
| dec_i | input | NUM_STATES | Decision bit for each state: bit k is the decision of state k |
| metric_i | input | NUM_STATES*MET_W | Path metrics; state k occupies bits [k*MET_W +: MET_W] |
| bit_o | output | 1 | Decoded bit |
| bit_valid_o | output | 1 | `bit_o` holds a decoded bit |

## Verification
A wrong slot counter or wrap would put decoded bits in the wrong order or mix up halves. That shows as mismatches against the encoder input within the next output burst. A wrong start state from the minimum search, a mishandled tie or a plain (non-wrapping) comparison would change the last six bits of that half's burst, about 97 cycles after the half closes. A fault in the predecessor step or in the stack would corrupt the whole burst, or change its length or its cycle of arrival.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  typedef enum logic [1:0] {
    TB_IDLE,
    TB_WAIT,
    TB_TRACE,
    TB_EMIT
  } tb_state_e;
endpackage

// File: rtl/tsu_surv_mem.sv
module tsu_surv_mem #(
  parameter int NUM_STATES = 64,
  parameter int DEPTH      = 62,
  localparam int SW  = $clog2(NUM_STATES),
  localparam int SAW = $clog2(DEPTH)
) (
  input  logic                  clk_i,
  input  logic                  we_i,
  input  logic [SAW-1:0]        waddr_i,
  input  logic [NUM_STATES-1:0] wdata_i,
  input  logic [SAW-1:0]        raddr_i,
  input  logic [SW-1:0]         rsel_i,
  output logic                  rbit_o
);
  logic [NUM_STATES-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rbit_o = mem_q[raddr_i][rsel_i];
endmodule

// File: rtl/tsu_min_find.sv
module tsu_min_find #(
  parameter int NUM_STATES = 64,
  parameter int MET_W      = 8,
  localparam int SW = $clog2(NUM_STATES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [NUM_STATES*MET_W-1:0] metrics_i,
  output logic                        done_o,
  output logic [SW-1:0]               best_o
);
  logic [MET_W-1:0] pm_q [NUM_STATES];
  logic [SW-1:0]    idx_q, best_idx_q;
  logic [MET_W-1:0] best_val_q, cur, diff;
  logic             active_q, take;

  assign cur  = pm_q[idx_q];
  assign diff = cur - best_val_q;
  // modular compare; strict so ties keep the lower index
  assign take = (idx_q == '0) || diff[MET_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_STATES; k++) pm_q[k] <= '0;
      idx_q      <= '0;
      best_idx_q <= '0;
      best_val_q <= '0;
      active_q   <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        for (int k = 0; k < NUM_STATES; k++) pm_q[k] <= metrics_i[k*MET_W +: MET_W];
        idx_q    <= '0;
        active_q <= 1'b1;
      end else if (active_q) begin
        if (take) begin
          best_idx_q <= idx_q;
          best_val_q <= cur;
        end
        if (idx_q == SW'(NUM_STATES-1)) begin
          active_q <= 1'b0;
          done_o   <= 1'b1;
        end
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign best_o = best_idx_q;
endmodule

// File: rtl/tsu_lifo.sv
module tsu_lifo #(
  parameter int DEPTH = 31,
  localparam int CW = $clog2(DEPTH+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          din_i,
  output logic          dout_o,
  output logic [CW-1:0] count_o
);
  logic [DEPTH-1:0] q_q;
  logic [CW-1:0]    sp_q, top_idx;

  assign top_idx = sp_q - CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q  <= '0;
      sp_q <= '0;
    end else if (push_i) begin
      q_q[sp_q] <= din_i;
      sp_q      <= sp_q + CW'(1);
    end else if (pop_i) begin
      sp_q <= top_idx;
    end
  end

  assign dout_o  = q_q[top_idx];
  assign count_o = sp_q;
endmodule

// File: rtl/tsu_trace_ctrl.sv
module tsu_trace_ctrl
  import tsu_pkg::*;
#(
  parameter int NUM_STATES = 64,
  parameter int HALF       = 31,
  parameter int DEPTH      = 62,
  localparam int SW  = $clog2(NUM_STATES),
  localparam int SAW = $clog2(DEPTH),
  localparam int STW = $clog2(HALF),
  localparam int CW  = $clog2(HALF+1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [SAW-1:0] top_i,
  input  logic           done_i,
  input  logic [SW-1:0]  best_i,
  output logic [SAW-1:0] raddr_o,
  output logic [SW-1:0]  rsel_o,
  input  logic           rbit_i,
  output logic           push_o,
  output logic           pop_o,
  output logic           push_bit_o,
  input  logic           lifo_bit_i,
  input  logic [CW-1:0]  lifo_cnt_i,
  output logic           busy_o,
  output logic           bit_o,
  output logic           bit_valid_o
);
  tb_state_e      st_q;
  logic [SAW-1:0] stage_q;
  logic [SW-1:0]  ptr_q;
  logic [STW-1:0] step_q;

  assign raddr_o    = stage_q;
  assign rsel_o     = ptr_q;
  assign push_o     = (st_q == TB_TRACE);
  assign pop_o      = (st_q == TB_EMIT);
  assign push_bit_o = ptr_q[SW-1];
  assign busy_o     = (st_q != TB_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= TB_IDLE;
      stage_q     <= '0;
      ptr_q       <= '0;
      step_q      <= '0;
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
    end else begin
      bit_valid_o <= 1'b0;
      unique case (st_q)
        TB_IDLE: if (start_i) begin
          stage_q <= top_i;
          st_q    <= TB_WAIT;
        end
        TB_WAIT: if (done_i) begin
          ptr_q  <= best_i;
          step_q <= '0;
          st_q   <= TB_TRACE;
        end
        TB_TRACE: begin
          ptr_q   <= {ptr_q[SW-2:0], rbit_i};
          stage_q <= stage_q - 1'b1;
          step_q  <= step_q + 1'b1;
          if (step_q == STW'(HALF-1)) st_q <= TB_EMIT;
        end
        TB_EMIT: begin
          bit_o       <= lifo_bit_i;
          bit_valid_o <= 1'b1;
          if (lifo_cnt_i == CW'(1)) st_q <= TB_IDLE;
        end
        default: st_q <= TB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsu_traceback_unit.sv
module tsu_traceback_unit #(
  parameter int NUM_STATES = 64,
  parameter int TB_LEN     = 30,
  parameter int MET_W      = 8,
  localparam int HALF  = TB_LEN + 1,
  localparam int DEPTH = 2 * HALF,
  localparam int SW    = $clog2(NUM_STATES),
  localparam int SAW   = $clog2(DEPTH),
  localparam int CW    = $clog2(HALF+1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        stage_valid_i,
  input  logic [NUM_STATES-1:0]       dec_i,
  input  logic [NUM_STATES*MET_W-1:0] metric_i,
  output logic                        bit_o,
  output logic                        bit_valid_o
);
  logic [SAW-1:0] wr_stage_q, raddr;
  logic           half_end, fnd_done, rbit, trace_busy;
  logic [SW-1:0]  best, rsel;
  logic           push, pop, push_bit, lifo_bit;
  logic [CW-1:0]  lifo_cnt;

  assign half_end = stage_valid_i &&
                    (wr_stage_q == SAW'(HALF-1) || wr_stage_q == SAW'(DEPTH-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            wr_stage_q <= '0;
    else if (stage_valid_i) wr_stage_q <= (wr_stage_q == SAW'(DEPTH-1)) ? '0 : wr_stage_q + 1'b1;
  end

  tsu_surv_mem #(.NUM_STATES(NUM_STATES), .DEPTH(DEPTH)) mem_i (
    .clk_i  (clk_i),
    .we_i   (stage_valid_i),
    .waddr_i(wr_stage_q),
    .wdata_i(dec_i),
    .raddr_i(raddr),
    .rsel_i (rsel),
    .rbit_o (rbit)
  );

  tsu_min_find #(.NUM_STATES(NUM_STATES), .MET_W(MET_W)) find_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (half_end),
    .metrics_i(metric_i),
    .done_o   (fnd_done),
    .best_o   (best)
  );

  tsu_trace_ctrl #(.NUM_STATES(NUM_STATES), .HALF(HALF), .DEPTH(DEPTH)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (half_end),
    .top_i      (wr_stage_q),
    .done_i     (fnd_done),
    .best_i     (best),
    .raddr_o    (raddr),
    .rsel_o     (rsel),
    .rbit_i     (rbit),
    .push_o     (push),
    .pop_o      (pop),
    .push_bit_o (push_bit),
    .lifo_bit_i (lifo_bit),
    .lifo_cnt_i (lifo_cnt),
    .busy_o     (trace_busy),
    .bit_o      (bit_o),
    .bit_valid_o(bit_valid_o)
  );

  tsu_lifo #(.DEPTH(HALF)) lifo_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .din_i  (push_bit),
    .dout_o (lifo_bit),
    .count_o(lifo_cnt)
  );
endmodule

// File: rtl/tsu_traceback_unit_chk.sv
module tsu_traceback_unit_chk #(
  parameter int HALF  = 31,
  parameter int DEPTH = 62,
  localparam int SAW = $clog2(DEPTH),
  localparam int BW  = $clog2(HALF+2)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           stage_valid_i,
  input logic           bit_valid_o,
  input logic [SAW-1:0] wr_stage_q,
  input logic           fnd_done,
  input logic           trace_busy
);
  logic [BW-1:0] burst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          burst_q <= '0;
    else if (bit_valid_o) burst_q <= burst_q + 1'b1;
    else                  burst_q <= '0;
  end

  // R2
  stage_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stage_q < SAW'(DEPTH));

  // R2
  stage_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_valid_i && wr_stage_q == SAW'(DEPTH-1)) |=> (wr_stage_q == '0));

  // R3
  no_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_valid_i && (wr_stage_q == SAW'(HALF-1) || wr_stage_q == SAW'(DEPTH-1)))
      |-> !trace_busy);

  // R3
  trace_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_valid_i && wr_stage_q == SAW'(HALF-1)) |=> trace_busy);

  // R6
  burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bit_valid_o) |-> (burst_q == BW'(HALF)));

  // R7
  quiet_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fnd_done |-> (!bit_valid_o && trace_busy));
endmodule

bind tsu_traceback_unit tsu_traceback_unit_chk #(.HALF(HALF), .DEPTH(DEPTH)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stage_valid_i(stage_valid_i),
  .bit_valid_o  (bit_valid_o),
  .wr_stage_q   (wr_stage_q),
  .fnd_done     (fnd_done),
  .trace_busy   (trace_busy)
);

// File: tb/tsu_traceback_unit_tb_top.sv
module tsu_traceback_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS    = 64;
  localparam int MW    = 8;
  localparam int HALF  = 31;
  localparam int NMAIN = 6 * HALF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stage_valid = 1'b0;
  logic [NS-1:0] dec = '0;
  logic [NS*MW-1:0] metric = '0;
  logic bit_out, bit_valid;

  int checks = 0, errors = 0;
  int cyc = 0, acc_cyc = 0, burst_cyc = 0;
  int out_n = 0;
  logic out_bits [1024];
  logic prev_valid = 1'b0;
  logic [NS-1:0] dq [HALF];
  logic in_bits [NMAIN];
  int pm [NS];
  logic [5:0] enc_st;
  bit finished = 0;

  tsu_traceback_unit #(.NUM_STATES(NS), .TB_LEN(HALF-1), .MET_W(MW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .stage_valid_i(stage_valid), .dec_i(dec),
    .metric_i(metric), .bit_o(bit_out), .bit_valid_o(bit_valid));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && bit_valid) begin
      if (!prev_valid) burst_cyc = cyc;
      out_bits[out_n] = bit_out;
      out_n++;
    end
    prev_valid = bit_valid;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic feed(input logic [NS-1:0] d, input logic [NS*MW-1:0] m, input bit last);
    @(negedge clk);
    stage_valid = 1'b1; dec = d; metric = m;
    @(posedge clk);
    #1;
    if (last) acc_cyc = cyc;
    @(negedge clk);
    stage_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [NS*MW-1:0] fill_metrics(input int v);
    logic [NS*MW-1:0] m;
    for (int k = 0; k < NS; k++) m[k*MW +: MW] = MW'(v);
    return m;
  endfunction

  // feed one half with decisions dq, then compare against a model traceback from exp_st
  task automatic run_half(input logic [NS*MW-1:0] last_m, input int exp_st, input string req);
    int base;
    logic [5:0] p;
    logic [HALF-1:0] exp_v, got_v;
    base = out_n;
    for (int t = 0; t < HALF; t++)
      feed(dq[t], (t == HALF-1) ? last_m : fill_metrics(100), t == HALF-1);
    while (out_n < base + HALF) @(negedge clk);
    p = 6'(exp_st);
    for (int t = HALF-1; t >= 0; t--) begin
      exp_v[t] = p[5];
      p = {p[4:0], dq[t][p]};
    end
    for (int t = 0; t < HALF; t++) got_v[t] = out_bits[base+t];
    check(got_v == exp_v, req, got_v, exp_v);
    check(burst_cyc - acc_cyc == 97, "R7 latency", burst_cyc - acc_cyc, 97);
  endtask

  function automatic logic [1:0] enc_out(input logic [6:0] r);
    return {^(r & 7'b1111001), ^(r & 7'b1011011)};
  endfunction

  initial begin
    logic [NS*MW-1:0] m;
    int base;
    repeat (3) @(negedge clk);
    check(bit_valid == 1'b0, "R1 reset valid", bit_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(bit_valid == 1'b0, "R1 idle valid", bit_valid, 0);

    // R4: unique minimum, all-zero decisions
    for (int t = 0; t < HALF; t++) dq[t] = '0;
    m = fill_metrics(100); m[37*MW +: MW] = 8'd20;
    run_half(m, 37, "R4 R1 min state 37");

    // R4 tie to lower index, R5 with all-one decisions
    for (int t = 0; t < HALF; t++) dq[t] = '1;
    m = fill_metrics(9); m[50*MW +: MW] = 8'd7; m[12*MW +: MW] = 8'd7;
    run_half(m, 12, "R4 R5 tie picks 12");

    // R9 modular compare: 250 counts as below 5 and 4
    for (int t = 0; t < HALF; t++) dq[t] = '0;
    m = fill_metrics(5); m[3*MW +: MW] = 8'd250; m[60*MW +: MW] = 8'd4;
    run_half(m, 3, "R9 wrap compare");

    // R5 R3 random decisions, second wrap of the slot counter
    for (int t = 0; t < HALF; t++) dq[t] = {$urandom, $urandom};
    m = fill_metrics(40); m[45*MW +: MW] = 8'd1;
    run_half(m, 45, "R5 R2 random decisions");

    // R8 R10 R2 R6: error-free encoded stream, stages overlap traceback
    enc_st = '0;
    for (int k = 0; k < NS; k++) pm[k] = (k == 0) ? 0 : 60;
    base = out_n;
    for (int n = 0; n < NMAIN; n++) begin
      logic b;
      logic [1:0] rx;
      int npm [NS];
      logic [NS-1:0] dv;
      b = 1'($urandom);
      in_bits[n] = b;
      rx = enc_out({b, enc_st});
      enc_st = {b, enc_st[5:1]};
      for (int s = 0; s < NS; s++) begin
        int c0, c1;
        logic [5:0] ns, p0, p1;
        logic [1:0] e0, e1;
        ns = 6'(s);
        p0 = {ns[4:0], 1'b0}; p1 = {ns[4:0], 1'b1};
        e0 = enc_out({ns[5], p0}); e1 = enc_out({ns[5], p1});
        c0 = pm[p0] + int'(e0[1] != rx[1]) + int'(e0[0] != rx[0]);
        c1 = pm[p1] + int'(e1[1] != rx[1]) + int'(e1[0] != rx[0]);
        dv[s] = (c1 < c0);
        npm[s] = (c1 < c0) ? c1 : c0;
      end
      for (int s = 0; s < NS; s++) begin
        pm[s] = npm[s];
        m[s*MW +: MW] = MW'(npm[s]);
      end
      feed(dv, m, 1'b0);
    end
    while (out_n < base + NMAIN) @(negedge clk);
    for (int n = 0; n < NMAIN; n++)
      check(out_bits[base+n] == in_bits[n], "R8 R10 decoded bit", out_bits[base+n], in_bits[n]);
    repeat (200) @(negedge clk);
    check(out_n == base + NMAIN, "R6 output count", out_n, base + NMAIN);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule